// File: doc/BRIEF.md
# Latched Fault Protection Controller for a Buck Regulator

This block watches the digital outputs of the comparators around a synchronous buck regulator and decides when the regulator must be shut down. Six conditions are watched: the peak current limit, output undervoltage, output overvoltage, the feedback-open/short condition, a short across the high-side switch, and die over-temperature. Each condition has its own filter. The undervoltage and feedback filters count system-clock cycles. The overvoltage filter counts switching-oscillator cycle starts, which arrive as a one-clock strobe. The current limit goes through a two-stage sequence. A hit at the start of a switching cycle first causes that cycle and the next eight to be skipped. A second hit in the eight cycles after the skip run then latches a fault.

Any qualified fault sets one latch. The latch turns on the output discharge load and stores a 3-bit code for the first fault that set it. The latch is cleared only by the synchronous reset, which stands for a power-on reset, or by taking the enable low. While the soft-start ramp is still below its "ready" level, the current-limit and undervoltage faults are masked. Over-temperature does not use the latch. It holds the controller in an internal reset and asks for the soft-start capacitor to be discharged until the cool-down comparator reports, so the regulator then goes through a full restart.

Top module: `fault_guard`

## Requirements
- R1: After reset, and one clock after `en_i` is sampled low, `fault_o`=0, `cause_o`=0, `skip_o`=0, `dis_load_o`=1 and `ss_dis_o`=1. Taking enable low clears a set fault latch.
- R2: When `ilim_i` is high in the clock where `cyc_start_i` is high and no over-current sequence is running, `skip_o` rises on the next clock. It stays high through the trigger cycle and the following OC_SKIP (8) cycles. It falls on the clock after the strobe that starts cycle OC_SKIP+1 (cycle 9).
- R3: An `ilim_i` hit on any clock of cycles 9 to 16 of the sequence latches a fault. A hit during cycles 1 to 8, or a mid-cycle hit after cycle 16, does not. The strobe that starts cycle 17 ends the sequence.
- R4: `uv_i` latches a fault once it has been high on UV_CLKS consecutive clocks. A single low clock restarts the count.
- R5: `ov_i` latches a fault when it is high without a break across OV_CYC (16) cycle-start strobes. A single low clock restarts the count.
- R6: `fbfault_i` latches a fault only when it is high on more than FB_CLKS consecutive clocks.
- R7: `hs_short_i` high on a single clock latches a fault.
- R8: While `ss_done_i` is low, the current-limit and undervoltage faults cannot set the latch, although pulse skipping still runs. The overvoltage, feedback and high-side faults are not masked.
- R9: `dis_load_o` is high on the clock after the latch is set or after enable is sampled low, and is low otherwise.
- R10: `cause_o` records the fault that set the latch: 1 over-current, 2 undervoltage, 3 overvoltage, 4 feedback, 5 high-side. If several faults fire on the same clock, the priority is high-side, then overvoltage, then feedback, then over-current, then undervoltage. Later faults do not change the code while the latch is set.
- R11: `ot_hot_i` sets an over-temperature hold. The hold raises `ss_dis_o` on the next clock and clears the fault latch one clock after that. The hold is released only by `ot_cool_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| en_i | input | 1 | Regulator enable; low clears the latch |
| cyc_start_i | input | 1 | One-clock strobe at each switching-cycle start |
| ilim_i | input | 1 | Current-limit comparator |
| uv_i | input | 1 | Output undervoltage comparator |
| ov_i | input | 1 | Output overvoltage comparator |
| fbfault_i | input | 1 | Output high while feedback low (open or shorted divider) |
| hs_short_i | input | 1 | High-side switch short detected |
| ss_done_i | input | 1 | Soft-start above its ready level |
| ot_hot_i | input | 1 | Die temperature above the trip level |
| ot_cool_i | input | 1 | Die temperature below the release level |
| fault_o | output | 1 | Fault latch |
| skip_o | output | 1 | Skip high-side pulse in the current cycle |
| dis_load_o | output | 1 | Output discharge load enable |
| ss_dis_o | output | 1 | Soft-start capacitor discharge request |
| cause_o | output | 3 | Code of the first fault |

## Verification
The bench sweeps each filter length one step below and at its threshold. A filter that is off by one would latch one clock or one strobe early or late. It also breaks a run with a single low clock to catch counters that do not restart. For the over-current sequence it moves a mid-cycle hit across cycles 8, 9, 16 and 17 and checks `skip_o` in every cycle, so that an off-by-one skip run or a window shifted by one cycle fails. Masking, cause priority with simultaneous faults, cause hold, and the over-temperature hold and release are each driven directly. A design that mixed up which faults are masked, or that overwrote the cause code, would report the wrong code or latch when it should not.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_OC   = 3'd1,
    CAUSE_UV   = 3'd2,
    CAUSE_OV   = 3'd3,
    CAUSE_FB   = 3'd4,
    CAUSE_HS   = 3'd5
  } cause_t;

  // Fixed priority: high-side, overvoltage, feedback, over-current, undervoltage
  function automatic cause_t pick_cause(input logic hs, input logic ov,
                                        input logic fb, input logic oc,
                                        input logic uv);
    if (hs)      return CAUSE_HS;
    else if (ov) return CAUSE_OV;
    else if (fb) return CAUSE_FB;
    else if (oc) return CAUSE_OC;
    else if (uv) return CAUSE_UV;
    else         return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/fg_persist.sv
// Persistence filter: trips when flag has stayed high for LIMIT step events.
module fg_persist #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic flag,
  input  logic step,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr || !flag)
      cnt_q <= '0;
    else if (step && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  assign trip = flag && step && (cnt_q == LAST) && !clr;

  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LAST);
  a_r5_drop_restarts: assert property (@(posedge clk) disable iff (clr)
    !flag |=> cnt_q == '0);
endmodule

// File: rtl/fg_ocseq.sv
// Over-current sequence: skip run after a cycle-start hit, then a watch window.
module fg_ocseq #(
  parameter int SKIP_CYC = 8,
  parameter int WIN_CYC  = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic cyc_start,
  input  logic ilim,
  output logic skip_o,
  output logic hit
);
  localparam int LASTI = SKIP_CYC + WIN_CYC;
  localparam int CW    = $clog2(LASTI + 2);
  localparam logic [CW-1:0] SKIP_L = CW'(SKIP_CYC);
  localparam logic [CW-1:0] LAST_L = CW'(LASTI);

  logic          act_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cur;
  logic          in_win;

  // Cycle index that the current clock belongs to (a strobe opens a new cycle)
  assign cur    = cyc_start ? cnt_q + 1'b1 : cnt_q;
  assign in_win = act_q && (cur > SKIP_L) && (cur <= LAST_L);
  assign hit    = in_win && ilim;

  always_ff @(posedge clk) begin
    if (clr) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      skip_o <= 1'b0;
    end else if (cyc_start) begin
      if (act_q && cnt_q != LAST_L) begin
        cnt_q  <= cnt_q + 1'b1;
        skip_o <= (cnt_q + 1'b1) <= SKIP_L;
      end else begin
        act_q  <= ilim;
        cnt_q  <= '0;
        skip_o <= ilim;
      end
    end
  end

  a_r2_skip_in_seq: assert property (@(posedge clk) disable iff (clr)
    skip_o |-> act_q);
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (clr)
    act_q |-> cnt_q <= LAST_L);
  a_r2_trigger: assert property (@(posedge clk) disable iff (clr)
    (cyc_start && ilim && !act_q) |=> (skip_o && act_q && cnt_q == '0));
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fg_pkg::*;
#(
  parameter int UV_CLKS = 200,
  parameter int FB_CLKS = 1400,
  parameter int OV_CYC  = 16,
  parameter int OC_SKIP = 8,
  parameter int OC_WIN  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       cyc_start_i,
  input  logic       ilim_i,
  input  logic       uv_i,
  input  logic       ov_i,
  input  logic       fbfault_i,
  input  logic       hs_short_i,
  input  logic       ss_done_i,
  input  logic       ot_hot_i,
  input  logic       ot_cool_i,
  output logic       fault_o,
  output logic       skip_o,
  output logic       dis_load_o,
  output logic       ss_dis_o,
  output logic [2:0] cause_o
);
  localparam int NF = 3;  // filtered sources: 0 undervoltage, 1 feedback, 2 overvoltage
  localparam int FLIM [NF] = '{UV_CLKS, FB_CLKS + 1, OV_CYC};

  logic          ot_q, ot_d, clr;
  logic [NF-1:0] f_flag, f_step, f_trip;
  logic          oc_hit, oc_trip, any_trip, fault_d;
  cause_t        cause_q, cause_d;

  assign clr = rst || !en_i || ot_q;

  assign f_flag = {ov_i, fbfault_i, uv_i && ss_done_i};
  assign f_step = {cyc_start_i, 1'b1, 1'b1};

  for (genvar g = 0; g < NF; g++) begin : g_filt
    fg_persist #(.LIMIT(FLIM[g])) u_filt (
      .clk  (clk),
      .clr  (clr),
      .flag (f_flag[g]),
      .step (f_step[g]),
      .trip (f_trip[g])
    );
  end

  fg_ocseq #(.SKIP_CYC(OC_SKIP), .WIN_CYC(OC_WIN)) u_oc (
    .clk       (clk),
    .clr       (clr),
    .cyc_start (cyc_start_i),
    .ilim      (ilim_i),
    .skip_o    (skip_o),
    .hit       (oc_hit)
  );

  assign oc_trip  = oc_hit && ss_done_i;
  assign any_trip = !clr && (hs_short_i || oc_trip || (|f_trip));

  always_comb begin
    fault_d = fault_o;
    cause_d = cause_q;
    if (clr) begin
      fault_d = 1'b0;
      cause_d = CAUSE_NONE;
    end else if (!fault_o && any_trip) begin
      fault_d = 1'b1;
      cause_d = pick_cause(hs_short_i, f_trip[2], f_trip[1], oc_trip, f_trip[0]);
    end
  end

  always_comb begin
    if (rst)            ot_d = 1'b0;
    else if (ot_hot_i)  ot_d = 1'b1;
    else if (ot_cool_i) ot_d = 1'b0;
    else                ot_d = ot_q;
  end

  always_ff @(posedge clk) begin
    fault_o    <= fault_d;
    cause_q    <= cause_d;
    ot_q       <= ot_d;
    dis_load_o <= rst || !en_i || fault_d;
    ss_dis_o   <= rst || !en_i || ot_d;
  end

  assign cause_o = cause_q;

  a_r1_enable_low: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!fault_o && cause_o == 3'd0 && dis_load_o && ss_dis_o));
  a_r9_fault_loads: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> dis_load_o);
  a_r10_cause_set: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> cause_o != 3'd0);
  a_r10_cause_clear: assert property (@(posedge clk) disable iff (rst)
    !fault_o |-> cause_o == 3'd0);
  a_r10_cause_held: assert property (@(posedge clk) disable iff (rst)
    (fault_o && en_i && !ot_q) |=> $stable(cause_o));
  a_r8_ss_mask: assert property (@(posedge clk) disable iff (rst)
    (!fault_o && !ss_done_i) |=>
      !(fault_o && (cause_o == 3'd1 || cause_o == 3'd2)));
  a_r11_hot_hold: assert property (@(posedge clk) disable iff (rst)
    ot_hot_i |=> ss_dis_o);
endmodule

// File: tb/sim_fault_guard.sv
module sim_fault_guard;
  localparam int UVN = 6;
  localparam int FBN = 10;
  localparam int OVN = 16;
  localparam int CP  = 4;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, cyc = 1'b0, ilim = 1'b0;
  logic uv = 1'b0, ov = 1'b0, fbf = 1'b0, hs = 1'b0, ssd = 1'b1;
  logic hot = 1'b0, cool = 1'b0;
  logic fault, skip, dload, ssdis;
  logic [2:0] cause;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  fault_guard #(.UV_CLKS(UVN), .FB_CLKS(FBN), .OV_CYC(OVN), .OC_SKIP(8), .OC_WIN(8)) u0 (
    .clk(clk), .rst(rst), .en_i(en), .cyc_start_i(cyc), .ilim_i(ilim),
    .uv_i(uv), .ov_i(ov), .fbfault_i(fbf), .hs_short_i(hs), .ss_done_i(ssd),
    .ot_hot_i(hot), .ot_cool_i(cool), .fault_o(fault), .skip_o(skip),
    .dis_load_o(dload), .ss_dis_o(ssdis), .cause_o(cause));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_fault();
    en = 1'b0; step(1);
    chk("R1 enable low clears latch", fault, 0);
    en = 1'b1; step(1);
  endtask

  task automatic strobe();
    cyc = 1'b1; step(1); cyc = 1'b0; step(CP - 1);
  endtask

  task automatic oc_run(input int hit_k, input logic ss, input int exp_f);
    ssd = ss;
    cyc = 1'b1; ilim = 1'b1; step(1); cyc = 1'b0; ilim = 1'b0;
    chk("R2 skip in trigger cycle", skip, 1);
    step(CP - 1);
    for (int k = 1; k <= 18; k++) begin
      cyc = 1'b1; step(1); cyc = 1'b0;
      chk($sformatf("R2 skip cycle %0d", k), skip, (k <= 8) ? 1 : 0);
      if (k == hit_k) ilim = 1'b1;
      step(1); ilim = 1'b0; step(CP - 2);
    end
    chk($sformatf("R3/R8 hit cycle %0d ss %0d", hit_k, ss), fault, exp_f);
    if (exp_f == 1) chk("R10 cause over-current", cause, 1);
    clear_fault();
    ssd = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset fault", fault, 0);
    chk("R1 reset cause", cause, 0);
    chk("R1 reset skip", skip, 0);
    chk("R1 reset load", dload, 1);
    chk("R1 reset ss discharge", ssdis, 1);
    rst = 1'b0; en = 1'b1; step(1);
    chk("R9 load off when enabled", dload, 0);
    chk("R11 ss discharge off", ssdis, 0);

    // R4 undervoltage persistence sweep
    for (int l = 1; l <= UVN; l++) begin
      uv = 1'b1; step(l); uv = 1'b0;
      chk($sformatf("R4 uv run %0d", l), fault, (l >= UVN) ? 1 : 0);
      if (l >= UVN) begin
        chk("R10 cause undervoltage", cause, 2);
        step(1);
        chk("R9 load on with fault", dload, 1);
      end
      clear_fault();
    end
    uv = 1'b1; step(UVN - 1); uv = 1'b0; step(1); uv = 1'b1; step(UVN - 1); uv = 1'b0;
    chk("R4 broken uv run", fault, 0);
    step(1);

    // R8 undervoltage masked during soft-start
    ssd = 1'b0; uv = 1'b1; step(3 * UVN); uv = 1'b0;
    chk("R8 uv masked", fault, 0);
    ssd = 1'b1; step(1);

    // R6 feedback fault, not masked
    ssd = 1'b0;
    for (int l = FBN; l <= FBN + 1; l++) begin
      fbf = 1'b1; step(l); fbf = 1'b0;
      chk($sformatf("R6 fb run %0d", l), fault, (l > FBN) ? 1 : 0);
      if (l > FBN) chk("R10 cause feedback", cause, 4);
      clear_fault();
    end

    // R7 high-side single clock, not masked
    hs = 1'b1; step(1); hs = 1'b0;
    chk("R7 hs latch", fault, 1);
    chk("R10 cause high-side", cause, 5);
    clear_fault();
    ssd = 1'b1;

    // R5 overvoltage strobe count
    for (int n = OVN - 1; n <= OVN; n++) begin
      ov = 1'b1;
      for (int s = 0; s < n; s++) strobe();
      ov = 1'b0;
      chk($sformatf("R5 ov strobes %0d", n), fault, (n >= OVN) ? 1 : 0);
      if (n >= OVN) chk("R10 cause overvoltage", cause, 3);
      clear_fault();
    end
    ov = 1'b1;
    for (int s = 0; s < OVN - 1; s++) strobe();
    ov = 1'b0; step(1); ov = 1'b1;
    for (int s = 0; s < OVN - 1; s++) strobe();
    ov = 1'b0;
    chk("R5 broken ov run", fault, 0);
    step(1);

    // R2/R3/R8 over-current sequence
    oc_run(8, 1'b1, 0);
    oc_run(9, 1'b1, 1);
    oc_run(16, 1'b1, 1);
    oc_run(17, 1'b1, 0);
    oc_run(12, 1'b0, 0);

    // R10 priority and hold
    uv = 1'b1; step(UVN - 1); hs = 1'b1; step(1); hs = 1'b0; uv = 1'b0;
    chk("R10 hs beats uv", cause, 5);
    clear_fault();
    uv = 1'b1; step(UVN); uv = 1'b0;
    hs = 1'b1; step(1); hs = 1'b0; step(1);
    chk("R10 cause held after later fault", cause, 2);
    chk("R10 latch stays set", fault, 1);

    // R11 over-temperature hold
    hot = 1'b1; step(1); hot = 1'b0;
    chk("R11 ss discharge on hot", ssdis, 1);
    step(1);
    chk("R11 hold clears latch", fault, 0);
    hs = 1'b1; step(1); hs = 1'b0;
    chk("R11 faults blocked in hold", fault, 0);
    step(3);
    chk("R11 hold waits for cool", ssdis, 1);
    cool = 1'b1; step(1); cool = 1'b0;
    chk("R11 released on cool", ssdis, 0);
    step(1);
    hs = 1'b1; step(1); hs = 1'b0;
    chk("R11 detection resumes", fault, 1);

    // R1 reset clears
    rst = 1'b1; step(1); rst = 1'b0; step(1);
    chk("R1 reset clears latch", fault, 0);
    chk("R1 reset clears cause", cause, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule